// File: doc/BRIEF.md
# Integer Execute Unit with Condition Codes

This block is the integer execute stage of a load/store RISC core. Each cycle it takes a first register operand and a second operand. The second operand is either a register value or a sign-extended 13-bit immediate. It also takes an operation code. It returns the destination result in the same cycle, without a register on the result path. It supports add and subtract, with and without the carry flag as carry-in. It also covers plain and inverted bitwise logic, XNOR, three kinds of shift, and access to an auxiliary Y register.

Four condition flags (negative, zero, overflow, carry) and the Y register are stored in the block. Arithmetic and logic operations change the flags only when `set_cc` is high. Shifts and the Y operations never change the flags. The operations with carry-in use the stored carry flag as it stands before the clock edge. Flags and Y are cleared by an asynchronous active-low reset. The block releases that reset on a clock edge.

Top module: `alu_cc_unit`

## Requirements
- R1: The second operand is `rs2_val` when `use_imm`=0. When `use_imm`=1 it is `imm_val` sign-extended from bit 12 to 32 bits.
- R2: `op_sel` codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 AND, 5 AND-NOT, 6 OR, 7 OR-NOT, 8 XOR, 9 XNOR, 10 shift-left-logical, 11 shift-right-logical, 12 shift-right-arithmetic, 13 read-Y, 14 write-Y and 15 reserved. Code 0 gives `rd_val` = rs1+op2 and code 2 gives `rd_val` = rs1−op2, both modulo 2^32.
- R3: Code 1 gives rs1+op2+C and code 3 gives rs1−op2−C, where C is the stored carry flag.
- R4: When an add form updates the flags, C becomes the carry out of bit 31. For a subtract form, C becomes the borrow, that is unsigned rs1 < op2 plus the borrow-in.
- R5: When an add or subtract updates the flags, V becomes the signed (two's-complement) overflow of the operation.
- R6: When flags update, N becomes result bit 31 and Z becomes 1 exactly when the result is zero.
- R7: Codes 4–9 give rs1&op2, rs1&~op2, rs1|op2, rs1|~op2, rs1^op2 and ~(rs1^op2). When they update the flags, V and C are cleared.
- R8: Flags change only on a clock edge with `op_valid`=1, `set_cc`=1 and a code from 0 to 9.
- R9: Shifts move rs1 by op2[4:0] only. A right arithmetic shift fills with rs1[31]. Shifts leave the flags unchanged even when `set_cc`=1.
- R10: Code 14 stores rs1^op2 into Y and returns 0 on `rd_val`. Code 13 returns Y. Y changes only on code 14.
- R11: After reset, all four flags are 0 and read-Y returns 0.
- R12: Code 15 returns 0 and changes neither the flags nor Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation issued this cycle; gates all state updates |
| op_sel | input | 4 | Operation code (see R2) |
| set_cc | input | 1 | Request to update the condition flags |
| use_imm | input | 1 | Select the immediate as the second operand |
| rs1_val | input | 32 | First source register value |
| rs2_val | input | 32 | Second source register value |
| imm_val | input | 13 | Signed immediate |
| rd_val | output | 32 | Destination result (combinational) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry/borrow flag |

## Verification
The assertions check on every cycle that the flags hold when no flag update is requested, and that logic operations clear V and C. They also check that Z agrees with the result of the previous cycle, that Y holds outside write-Y, that arithmetic right shifts keep the sign, and that the reserved code returns zero. Only the bench scenarios can show the exact sums, differences and borrow values. The same applies to the carry chained from one operation into the next, the immediate sign extension, the masking of the shift amount and the Y write-then-read sequence.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IMM_W  = 13;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_SUBC = 4'd3,
    OP_AND  = 4'd4,  OP_ANDN = 4'd5,  OP_OR   = 4'd6,  OP_ORN  = 4'd7,
    OP_XOR  = 4'd8,  OP_XNOR = 4'd9,  OP_SLL  = 4'd10, OP_SRL  = 4'd11,
    OP_SRA  = 4'd12, OP_RDY  = 4'd13, OP_WRY  = 4'd14, OP_RSV  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_sub,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         c_flag,
  output logic         v_flag
);
  logic [W-1:0] b_eff;
  logic         cin_eff;
  logic [W:0]   ext;

  always_comb begin
    b_eff   = is_sub ? ~b : b;
    cin_eff = is_sub ? ~carry_in : carry_in;
    ext     = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin_eff};
    sum     = ext[W-1:0];
    c_flag  = is_sub ? ~ext[W] : ext[W];
    v_flag  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned W = 32
) (
  input  alu_cc_pkg::alu_op_e op,
  input  logic [W-1:0]        a,
  input  logic [W-1:0]        b,
  output logic [W-1:0]        res
);
  import alu_cc_pkg::*;

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_ANDN: res = a & ~b;
      OP_OR:   res = a | b;
      OP_ORN:  res = a | ~b;
      OP_XOR:  res = a ^ b;
      OP_XNOR: res = ~(a ^ b);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned W   = 32,
  localparam int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] amt,
  input  logic           go_left,
  input  logic           arith,
  output logic [W-1:0]   res
);
  logic [W-1:0] lstg [SHW+1];
  logic [W-1:0] rstg [SHW+1];
  logic         fill;

  assign fill    = arith & a[W-1];
  assign lstg[0] = a;
  assign rstg[0] = a;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int unsigned D = 1 << s;
    assign lstg[s+1] = amt[s] ? {lstg[s][W-1-D:0], {D{1'b0}}} : lstg[s];
    assign rstg[s+1] = amt[s] ? {{D{fill}}, rstg[s][W-1:D]}   : rstg[s];
  end

  assign res = go_left ? lstg[SHW] : rstg[SHW];
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit #(
  parameter int unsigned W    = 32,
  parameter int unsigned IMMW = 13,
  localparam int unsigned SHW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [3:0]      op_sel,
  input  logic            set_cc,
  input  logic            use_imm,
  input  logic [W-1:0]    rs1_val,
  input  logic [W-1:0]    rs2_val,
  input  logic [IMMW-1:0] imm_val,
  output logic [W-1:0]    rd_val,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_v,
  output logic            flag_c
);
  import alu_cc_pkg::*;

  // reset: asynchronous assert, release on a clock edge
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  alu_op_e      op;
  logic [W-1:0] op2, y_q, y_d;
  cc_t          cc_q, cc_d;
  logic         cc_en, y_en, is_arith, is_logic;

  assign op  = alu_op_e'(op_sel);
  assign op2 = use_imm ? {{(W-IMMW){imm_val[IMMW-1]}}, imm_val} : rs2_val;

  // datapath pieces
  logic [W-1:0] as_sum, lg_res, sh_res;
  logic         as_c, as_v;

  alu_addsub #(.W(W)) u_addsub (
    .a(rs1_val), .b(op2),
    .is_sub(op == OP_SUB || op == OP_SUBC),
    .carry_in((op == OP_ADDC || op == OP_SUBC) & cc_q.c),
    .sum(as_sum), .c_flag(as_c), .v_flag(as_v)
  );

  alu_logic #(.W(W)) u_logic (.op(op), .a(rs1_val), .b(op2), .res(lg_res));

  alu_shifter #(.W(W)) u_shift (
    .a(rs1_val), .amt(op2[SHW-1:0]),
    .go_left(op == OP_SLL), .arith(op == OP_SRA), .res(sh_res)
  );

  // result select
  always_comb begin
    is_arith = 1'b0;
    is_logic = 1'b0;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
        rd_val = as_sum; is_arith = 1'b1;
      end
      OP_AND, OP_ANDN, OP_OR, OP_ORN, OP_XOR, OP_XNOR: begin
        rd_val = lg_res; is_logic = 1'b1;
      end
      OP_SLL, OP_SRL, OP_SRA: rd_val = sh_res;
      OP_RDY:                 rd_val = y_q;
      default:                rd_val = '0;
    endcase
  end

  // next state
  always_comb begin
    cc_en  = op_valid & set_cc & (is_arith | is_logic);
    y_en   = op_valid & (op == OP_WRY);
    cc_d.n = rd_val[W-1];
    cc_d.z = (rd_val == '0);
    cc_d.v = is_arith & as_v;
    cc_d.c = is_arith & as_c;
    y_d    = rs1_val ^ op2;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cc_q <= '0;
      y_q  <= '0;
    end else begin
      if (cc_en) cc_q <= cc_d;
      if (y_en)  y_q  <= y_d;
    end
  end

  assign flag_n = cc_q.n;
  assign flag_z = cc_q.z;
  assign flag_v = cc_q.v;
  assign flag_c = cc_q.c;

  // checks on every cycle
  assert_cc_hold_R8: assert property (@(posedge clk) disable iff (!rst_q)
    !(op_valid && set_cc && op_sel < 4'd10) |=> $stable({flag_n, flag_z, flag_v, flag_c}));

  assert_logic_clr_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && set_cc && op_sel >= 4'd4 && op_sel <= 4'd9) |=> (!flag_v && !flag_c));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && set_cc && op_sel < 4'd10) |=> (flag_z == ($past(rd_val) == '0)));

  assert_y_hold_R10: assert property (@(posedge clk) disable iff (!rst_q)
    !(op_valid && op_sel == 4'd14) |=> $stable(y_q));

  assert_sra_sign_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (op_sel == 4'd12) |-> (rd_val[W-1] == rs1_val[W-1]));

  assert_reserved_R12: assert property (@(posedge clk) disable iff (!rst_q)
    (op_sel == 4'd15) |-> (rd_val == '0));
endmodule

// File: tb/sim_alu_cc_unit.sv
`timescale 1ns/1ps
module sim_alu_cc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, set_cc, use_imm;
  logic [3:0]  op_sel;
  logic [31:0] rs1_val, rs2_val, rd_val;
  logic [12:0] imm_val;
  logic        flag_n, flag_z, flag_v, flag_c;

  int checks = 0;
  int errors = 0;
  logic [31:0] got_rd;

  always #2 clk = ~clk;

  alu_cc_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .set_cc(set_cc), .use_imm(use_imm), .rs1_val(rs1_val), .rs2_val(rs2_val),
    .imm_val(imm_val), .rd_val(rd_val), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic        imm_sel;
    logic [31:0] a;
    logic [31:0] b;
    logic [12:0] imm;
    logic [31:0] r;
    logic [3:0]  nzvc;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 1'b0, 32'h1,        32'h2,        13'h0,    32'h3,        4'b0000}, // R2
    '{4'd0, 1'b0, 32'hffffffff, 32'h1,        13'h0,    32'h0,        4'b0101}, // R4 R6
    '{4'd0, 1'b0, 32'h7fffffff, 32'h1,        13'h0,    32'h80000000, 4'b1010}, // R5
    '{4'd0, 1'b1, 32'h10,       32'h0,        13'h1fff, 32'hf,        4'b0001}, // R1
    '{4'd2, 1'b0, 32'h5,        32'h3,        13'h0,    32'h2,        4'b0000}, // R2
    '{4'd2, 1'b0, 32'h3,        32'h5,        13'h0,    32'hfffffffe, 4'b1001}, // R4
    '{4'd2, 1'b0, 32'h80000000, 32'h1,        13'h0,    32'h7fffffff, 4'b0010}, // R5
    '{4'd2, 1'b0, 32'h5,        32'h5,        13'h0,    32'h0,        4'b0100}, // R6
    '{4'd4, 1'b0, 32'hf0f0f0f0, 32'hff00ff00, 13'h0,    32'hf000f000, 4'b1000}, // R7
    '{4'd5, 1'b0, 32'hf0f0f0f0, 32'hff00ff00, 13'h0,    32'h00f000f0, 4'b0000}, // R7
    '{4'd6, 1'b0, 32'h0f0f0000, 32'h0000ffff, 13'h0,    32'h0f0fffff, 4'b0000}, // R7
    '{4'd7, 1'b0, 32'h0,        32'hffffffff, 13'h0,    32'h0,        4'b0100}, // R7
    '{4'd8, 1'b0, 32'h12345678, 32'h12345678, 13'h0,    32'h0,        4'b0100}, // R7
    '{4'd9, 1'b0, 32'h0,        32'h0,        13'h0,    32'hffffffff, 4'b1000}, // R7
    '{4'd0, 1'b1, 32'h64,       32'h0,        13'h0fff, 32'h1063,     4'b0000}  // R1
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive at negedge, capture rd before the edge, leave idle just after it
  task automatic do_op(input logic [3:0] op, input logic sc, input logic im,
                       input logic [31:0] a, input logic [31:0] b, input logic [12:0] imm,
                       input logic vld = 1'b1);
    @(negedge clk);
    op_sel = op; set_cc = sc; use_imm = im;
    rs1_val = a; rs2_val = b; imm_val = imm; op_valid = vld;
    #1 got_rd = rd_val;
    @(posedge clk);
    #1 op_valid = 1'b0; set_cc = 1'b0;
  endtask

  function automatic logic [31:0] flags();
    return {28'h0, flag_n, flag_z, flag_v, flag_c};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    op_valid = 0; set_cc = 0; use_imm = 0; op_sel = 0;
    rs1_val = 0; rs2_val = 0; imm_val = 0;
    do_reset();

    // R11 reset state
    chk("R11 flags after reset", flags(), 32'h0);
    do_op(4'd13, 1'b0, 1'b0, 32'h0, 32'h0, 13'h0);
    chk("R11 Y after reset", got_rd, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].op, 1'b1, VECS[i].imm_sel, VECS[i].a, VECS[i].b, VECS[i].imm);
      chk($sformatf("R2/R7 result vec %0d", i), got_rd, VECS[i].r);
      chk($sformatf("R4/R5/R6 flags vec %0d", i), flags(), {28'h0, VECS[i].nzvc});
    end

    // R3 carry chaining
    do_op(4'd0, 1'b1, 1'b0, 32'hffffffff, 32'h1, 13'h0);
    do_op(4'd1, 1'b0, 1'b0, 32'h5, 32'h6, 13'h0);
    chk("R3 addc with C=1", got_rd, 32'hc);
    chk("R8 flags kept without set_cc", flags(), 32'h5);
    do_op(4'd3, 1'b1, 1'b0, 32'ha, 32'h3, 13'h0);
    chk("R3 subc with C=1", got_rd, 32'h6);
    chk("R4 subc flags", flags(), 32'h0);
    do_op(4'd3, 1'b1, 1'b0, 32'h0, 32'h0, 13'h0);
    chk("R3 subc with C=0", got_rd, 32'h0);
    chk("R6 subc zero", flags(), 32'h4);
    do_op(4'd2, 1'b1, 1'b0, 32'h0, 32'h1, 13'h0);
    do_op(4'd3, 1'b1, 1'b0, 32'h0, 32'h0, 13'h0);
    chk("R3 subc borrow-in", got_rd, 32'hffffffff);
    chk("R4 borrow from borrow-in", flags(), 32'h9);
    do_op(4'd1, 1'b1, 1'b0, 32'hffffffff, 32'h0, 13'h0);
    chk("R3 addc wrap", got_rd, 32'h0);
    chk("R4 addc carry out", flags(), 32'h5);

    // R8 op_valid low blocks updates
    do_op(4'd0, 1'b1, 1'b0, 32'h40000000, 32'h40000000, 13'h0, 1'b0);
    chk("R8 flags kept with op_valid=0", flags(), 32'h5);

    // R9 shifts
    do_op(4'd10, 1'b1, 1'b0, 32'h1, 32'h21, 13'h0);
    chk("R9 sll uses low 5 bits", got_rd, 32'h2);
    do_op(4'd11, 1'b1, 1'b0, 32'h80000000, 32'h4, 13'h0);
    chk("R9 srl", got_rd, 32'h08000000);
    do_op(4'd12, 1'b1, 1'b0, 32'h80000000, 32'h4, 13'h0);
    chk("R9 sra negative", got_rd, 32'hf8000000);
    do_op(4'd12, 1'b1, 1'b0, 32'h40000000, 32'h4, 13'h0);
    chk("R9 sra positive", got_rd, 32'h04000000);
    do_op(4'd12, 1'b1, 1'b1, 32'h80000000, 32'h0, 13'h1fff);
    chk("R9 sra by 31 from immediate", got_rd, 32'hffffffff);
    chk("R9 shifts leave flags", flags(), 32'h5);

    // R10 Y access
    do_op(4'd14, 1'b1, 1'b0, 32'h0f0f0f0f, 32'h00ff00ff, 13'h0);
    chk("R10 write-Y returns zero", got_rd, 32'h0);
    chk("R10 write-Y leaves flags", flags(), 32'h5);
    do_op(4'd13, 1'b0, 1'b0, 32'h0, 32'h0, 13'h0);
    chk("R10 read-Y", got_rd, 32'h0ff00ff0);
    do_op(4'd0, 1'b0, 1'b0, 32'h1, 32'h1, 13'h0);
    do_op(4'd13, 1'b0, 1'b0, 32'h0, 32'h0, 13'h0);
    chk("R10 Y kept by other ops", got_rd, 32'h0ff00ff0);

    // R12 reserved code
    do_op(4'd15, 1'b1, 1'b0, 32'h12345678, 32'h1, 13'h0);
    chk("R12 reserved returns zero", got_rd, 32'h0);
    chk("R12 reserved keeps flags", flags(), 32'h5);
    do_op(4'd13, 1'b0, 1'b0, 32'h0, 32'h0, 13'h0);
    chk("R12 reserved keeps Y", got_rd, 32'h0ff00ff0);

    // R11 reset in mid-run
    do_reset();
    chk("R11 flags after second reset", flags(), 32'h0);
    do_op(4'd13, 1'b0, 1'b0, 32'h0, 32'h0, 13'h0);
    chk("R11 Y after second reset", got_rd, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule